// File: doc/BRIEF.md
# DMA Burst Length Splitter

This block sits between a DMA engine's transfer scheduler and its bus master. It takes one request naming a direction and a total number of beats. It breaks that request into a series of bus bursts. No burst is longer than the programmed maximum burst length. Every burst except the last carries exactly that maximum. The last burst carries whatever remains.

The maximum comes from a 6-bit power-of-two burst-length field, optionally scaled by eight. A separate-length mode lets the main field govern only transmit transfers, while receive transfers take their limit from a second field. The configuration is written through plain strobe-and-data pins into internal registers. Those registers are sampled once, when a request is accepted. If the field that applies holds an unsupported value, the request is swallowed and an error pulse is raised.

The request side and the burst side are both valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the acceptance of a non-empty legal request until its final burst is handshaken. A burst is offered with `bst_valid`. While `bst_ready` is low, the burst stays on the port with `bst_len`, `bst_dir` and `bst_last` unchanged. The downstream side can therefore stall each burst for any number of cycles.

Top module: `dbs_burst_split`

## Requirements
- R1: After reset the burst-length fields both hold 1, the x8 scaling is off and separate-length mode is off. A 3-beat request made with no configuration write therefore yields three 1-beat bursts. In reset, and with no request pending, `req_ready`=1, `bst_valid`=0 and `err`=0.
- R2: A request of N beats with effective maximum M yields floor(N/M) bursts of M beats, plus one burst of N mod M beats when that remainder is nonzero. The lengths add up to N. `bst_last`=1 only on the final burst.
- R3: When `cfg_x8`=1, the effective maximum is eight times the selected field. A field of 8 gives 64 beats, and a field of 32 gives 256 beats.
- R4: `req_dir` 1 means transmit and 0 means receive. With `cfg_sep`=1, transmit transfers use the main field and receive transfers use the receive field. With `cfg_sep`=0, both directions use the main field.
- R5: A field value is supported only when exactly one of its six bits is set, giving 1, 2, 4, 8, 16 or 32. A non-empty request whose selected field is unsupported is accepted and issues no burst. `err` is then 1 for exactly the one cycle after acceptance.
- R6: `req_ready` is 0 from the cycle after a non-empty legal request is accepted until the cycle after its final burst is handshaken. In that following cycle it is 1 again.
- R7: While `bst_valid`=1 and `bst_ready`=0, the next cycle still shows `bst_valid`=1 with the same `bst_len`, `bst_dir` and `bst_last`.
- R8: A request of 0 beats is accepted and produces neither a burst nor an error.
- R9: A request uses the configuration held in the registers at its acceptance edge. A configuration write on that same edge applies only from the next request on. A write made during a transfer does not alter that transfer's bursts.
- R10: `bst_dir` equals the `req_dir` of the request being split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads the four configuration fields below |
| cfg_tx_blen | input | 6 | Main burst-length field (power of two) |
| cfg_rx_blen | input | 6 | Receive burst-length field, used in separate-length mode |
| cfg_x8 | input | 1 | Multiply the selected field by eight |
| cfg_sep | input | 1 | Separate-length mode: main field governs transmit only |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block can take a request |
| req_beats | input | BEAT_W (16) | Total beats of the transfer |
| req_dir | input | 1 | 1 = transmit, 0 = receive |
| bst_valid | output | 1 | Burst offered |
| bst_ready | input | 1 | Burst taken by the bus side |
| bst_len | output | LEN_W (9) | Beats in this burst |
| bst_dir | output | 1 | Direction of this burst |
| bst_last | output | 1 | Final burst of the transfer |
| err | output | 1 | One-cycle pulse: request dropped for an unsupported field |

## Verification
Two events can land on the same clock edge: a configuration write and the acceptance of a request. The bench provokes this by raising `cfg_wr` with a new main field in the same cycle as `req_valid`. It then judges the outcome by the burst lengths that follow: they must match the old field. A second write is made part way through that transfer, while bursts are being stalled. The bench confirms that the remaining bursts keep their length and that the next request picks up the newest value.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int FIELD_W  = 6;
  localparam int X8_SHIFT = 3;

  typedef logic [FIELD_W-1:0] blen_t;

  typedef struct packed {
    blen_t tx_blen;
    blen_t rx_blen;
    logic  x8;
    logic  sep;
  } cfg_t;

  // A supported field has exactly one bit set: 1,2,4,8,16,32.
  function automatic logic blen_supported(blen_t f);
    int ones;
    ones = 0;
    for (int i = 0; i < FIELD_W; i++) ones += int'(f[i]);
    return ones == 1;
  endfunction
endpackage

// File: rtl/dbs_cfg_regs.sv
module dbs_cfg_regs
  import dbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cfg_t wdata,
  output cfg_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.tx_blen <= blen_t'(1);
      q.rx_blen <= blen_t'(1);
      q.x8      <= 1'b0;
      q.sep     <= 1'b0;
    end else if (wr) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/dbs_limit.sv
module dbs_limit
  import dbs_pkg::*;
#(
  parameter int LEN_W = FIELD_W + X8_SHIFT
) (
  input  cfg_t             cfg,
  input  logic             dir_tx,
  output logic [LEN_W-1:0] max_len,
  output logic             legal
);
  blen_t            sel;
  logic [LEN_W-1:0] base;

  always_comb begin
    sel     = (cfg.sep && !dir_tx) ? cfg.rx_blen : cfg.tx_blen;
    base    = LEN_W'(sel);
    max_len = cfg.x8 ? (base << X8_SHIFT) : base;
    legal   = blen_supported(sel);
  end
endmodule

// File: rtl/dbs_splitter.sv
module dbs_splitter #(
  parameter int BEAT_W = 16,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_dir,
  input  logic [LEN_W-1:0]  lim_max,
  input  logic              lim_legal,
  output logic              bst_valid,
  input  logic              bst_ready,
  output logic [LEN_W-1:0]  bst_len,
  output logic              bst_dir,
  output logic              bst_last,
  output logic              err
);
  logic              busy_q;
  logic [BEAT_W-1:0] rem_q;
  logic [LEN_W-1:0]  max_q;
  logic              dir_q;
  logic              err_q;
  logic [BEAT_W-1:0] max_ext;
  logic              accept;

  // BEAT_W is expected to be at least LEN_W.
  assign max_ext   = BEAT_W'(max_q);
  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;
  assign bst_valid = busy_q;
  assign bst_dir   = dir_q;
  assign bst_last  = rem_q <= max_ext;
  assign bst_len   = bst_last ? LEN_W'(rem_q) : max_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      max_q  <= LEN_W'(1);
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (accept) begin
        if (req_beats != '0) begin
          if (lim_legal) begin
            busy_q <= 1'b1;
            rem_q  <= req_beats;
            max_q  <= lim_max;
            dir_q  <= req_dir;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (busy_q && bst_ready) begin
        rem_q <= rem_q - BEAT_W'(bst_len);
        if (bst_last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbs_burst_split.sv
module dbs_burst_split
  import dbs_pkg::*;
#(
  parameter int BEAT_W = 16,
  localparam int LEN_W = FIELD_W + X8_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_tx_blen,
  input  logic [5:0]        cfg_rx_blen,
  input  logic              cfg_x8,
  input  logic              cfg_sep,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_dir,
  output logic              bst_valid,
  input  logic              bst_ready,
  output logic [LEN_W-1:0]  bst_len,
  output logic              bst_dir,
  output logic              bst_last,
  output logic              err
);
  cfg_t             wdata;
  cfg_t             cfg_q;
  logic [LEN_W-1:0] lim_max;
  logic             lim_legal;

  assign wdata = '{tx_blen: cfg_tx_blen, rx_blen: cfg_rx_blen, x8: cfg_x8, sep: cfg_sep};

  dbs_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(wdata), .q(cfg_q)
  );

  dbs_limit #(.LEN_W(LEN_W)) u_lim (
    .cfg(cfg_q), .dir_tx(req_dir), .max_len(lim_max), .legal(lim_legal)
  );

  dbs_splitter #(.BEAT_W(BEAT_W), .LEN_W(LEN_W)) u_split (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_beats(req_beats), .req_dir(req_dir),
    .lim_max(lim_max), .lim_legal(lim_legal),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_len(bst_len),
    .bst_dir(bst_dir), .bst_last(bst_last), .err(err)
  );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int BEAT_W = 16,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BEAT_W-1:0] req_beats,
  input logic              bst_valid,
  input logic              bst_ready,
  input logic [LEN_W-1:0]  bst_len,
  input logic              bst_dir,
  input logic              bst_last,
  input logic              err
);
  a_r6_ready_low_while_bursting: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !req_ready);

  a_r6_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_ready && bst_last) |=> (req_ready && !bst_valid));

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=>
      (bst_valid && $stable(bst_len) && $stable(bst_dir) && $stable(bst_last)));

  a_r2_full_bursts_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_last) |-> $onehot(bst_len));

  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_len != '0));

  a_r5_err_issues_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!bst_valid && $past(req_valid && req_ready)));

  a_r8_zero_request_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_beats == '0) |=> (!bst_valid && !err));
endmodule

bind dbs_burst_split dbs_checker #(.BEAT_W(BEAT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_beats(req_beats), .bst_valid(bst_valid), .bst_ready(bst_ready),
  .bst_len(bst_len), .bst_dir(bst_dir), .bst_last(bst_last), .err(err)
);

// File: tb/sim_dbs_burst_split.sv
`timescale 1ns/1ps
module sim_dbs_burst_split;
  localparam int BEAT_W = 16;
  localparam int LEN_W  = 9;
  localparam int NV     = 11;

  // Columns: main field, rx field, x8, sep, dir, beats, expected max, expect err, requirement
  localparam int T_TX  [NV] = '{4, 32, 8, 2, 2, 32, 3, 1, 0, 16, 5};
  localparam int T_RX  [NV] = '{1, 1, 1, 16, 16, 4, 1, 0, 4, 1, 8};
  localparam int T_X8  [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int T_SEP [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 1, 0, 1};
  localparam int T_DIR [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 0};
  localparam int T_BT  [NV] = '{10, 70, 130, 33, 5, 256, 5, 5, 4, 16, 20};
  localparam int T_MAX [NV] = '{4, 32, 64, 16, 2, 256, 0, 0, 0, 16, 8};
  localparam int T_ERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0};
  localparam int T_REQ [NV] = '{2, 2, 3, 4, 4, 3, 5, 5, 5, 2, 4}; // R2 R3 R4 R5 rows

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_tx_blen = '0, cfg_rx_blen = '0;
  logic cfg_x8 = 1'b0, cfg_sep = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic req_ready, bst_valid, bst_dir, bst_last, err;
  logic bst_ready = 1'b0;
  logic [LEN_W-1:0] bst_len;

  int checks = 0;
  int errors = 0;
  int phase = 0;

  always #2.5 clk = ~clk;

  dbs_burst_split #(.BEAT_W(BEAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tx_blen(cfg_tx_blen),
    .cfg_rx_blen(cfg_rx_blen), .cfg_x8(cfg_x8), .cfg_sep(cfg_sep),
    .req_valid(req_valid), .req_ready(req_ready), .req_beats(req_beats), .req_dir(req_dir),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_len(bst_len),
    .bst_dir(bst_dir), .bst_last(bst_last), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int tx, input int rx, input int x8, input int sep);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tx_blen = 6'(tx); cfg_rx_blen = 6'(rx);
    cfg_x8 = 1'(x8); cfg_sep = 1'(sep);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Returns at the negedge after the accepting edge.
  task automatic send(input int dir, input int beats, input string req);
    @(negedge clk);
    chk(req_ready == 1'b1, req, int'(req_ready), 1);
    req_valid = 1'b1; req_dir = 1'(dir); req_beats = BEAT_W'(beats);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Starts at a negedge; walks bursts with a stalling ready pattern.
  task automatic collect(input int emax, input int beats, input int dir, input string req);
    int rem = beats;
    int guard = 0;
    while (rem > 0 && guard < 4000) begin
      bit rdy;
      guard++;
      rdy = (phase % 3) != 2;
      phase++;
      bst_ready = rdy;
      chk(bst_valid == 1'b1, {req, " valid during transfer"}, int'(bst_valid), 1);
      chk(req_ready == 1'b0, "R6 busy", int'(req_ready), 0);
      if (bst_valid && rdy) begin
        int exp;
        exp = (rem < emax) ? rem : emax;
        chk(int'(bst_len) == exp, {req, " len"}, int'(bst_len), exp);
        chk(bst_last == (rem <= emax), "R2 last flag", int'(bst_last), int'(rem <= emax));
        chk(int'(bst_dir) == dir, "R10 dir", int'(bst_dir), dir);
        rem -= exp;
      end
      @(negedge clk);
    end
    bst_ready = 1'b0;
    chk(rem == 0, {req, " beats left"}, rem, 0);
    chk(bst_valid == 1'b0 && req_ready == 1'b1, "R6 ready after last",
        int'(req_ready), 1);
  endtask

  task automatic expect_err(input string req);
    chk(err == 1'b1, {req, " err pulse"}, int'(err), 1);
    chk(bst_valid == 1'b0, {req, " no burst"}, int'(bst_valid), 0);
    @(negedge clk);
    chk(err == 1'b0, {req, " err one cycle"}, int'(err), 0);
    chk(bst_valid == 1'b0 && req_ready == 1'b1, {req, " idle"}, int'(bst_valid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset outputs
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(bst_valid == 1'b0 && err == 1'b0, "R1 quiet in reset", int'(bst_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default field is 1 with no configuration written
    send(1, 3, "R1");
    collect(1, 3, 1, "R1");

    // R8: empty request
    send(0, 0, "R8");
    chk(bst_valid == 1'b0 && err == 1'b0, "R8 nothing after empty", int'(bst_valid), 0);
    @(negedge clk);
    chk(bst_valid == 1'b0 && err == 1'b0 && req_ready, "R8 still idle", int'(bst_valid), 0);

    // Table rows: R2 splitting, R3 x8 scaling, R4 separate mode, R5 unsupported field
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", T_REQ[i], i);
      cfg_write(T_TX[i], T_RX[i], T_X8[i], T_SEP[i]);
      send(T_DIR[i], T_BT[i], tag);
      if (T_ERR[i] != 0) expect_err(tag);
      else collect(T_MAX[i], T_BT[i], T_DIR[i], tag);
    end

    // R9: write on the acceptance edge, then a write mid-transfer
    cfg_write(2, 1, 0, 0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tx_blen = 6'd8; cfg_rx_blen = 6'd1; cfg_x8 = 1'b0; cfg_sep = 1'b0;
    req_valid = 1'b1; req_dir = 1'b1; req_beats = BEAT_W'(8);
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    fork
      collect(2, 8, 1, "R9 old config");
      begin
        @(negedge clk);
        cfg_write(4, 1, 0, 0);
      end
    join
    send(1, 9, "R9");
    collect(4, 9, 1, "R9 newest config");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule